// File: doc/BRIEF.md
# SPI Host Interrupt and Error Combiner

This block gathers the status events and error conditions of an SPI host controller into two interrupt lines: one for errors and one for transfer events. Error conditions arrive as single-cycle pulses from the FIFOs and the command sequencer. Each pulse sets a sticky error status bit. Transfer events arrive as levels. Both groups pass through their own enable masks and feed a two-bit interrupt state register. A separate interrupt enable register then gates that state onto the output pins.

Software reaches the block through a simple write port and a registered read port. A write-only test register can force interrupt state bits. A write-only alert test register produces a one-cycle pulse on a fatal alert output. The state is re-evaluated every cycle. A bit that is cleared while its enabled source is still present is set again at once.

Top module: `spi_host_irq_agg`

Register word addresses: 0 interrupt state, 1 interrupt enable, 2 interrupt test, 3 alert test, 4 error status, 5 error enable, 6 event enable.

## Requirements
- R1: After a synchronous reset the following values hold: interrupt state, interrupt enable, error status and event enable are 0; error enable is 0x1F; irq_err_o, irq_evt_o and alert_fatal_o are 0.
- R2: The error status bits are 0 command busy, 1 TX overflow, 2 RX underflow, 3 command invalid and 4 chip-select ID invalid. A pulse on err_set_i[i] sets bit i, and the bit stays set. Writing 1 to bit i at address 4 clears it. If a set and a clear arrive in the same cycle, the set wins.
- R3: Interrupt state bit 0 is set in the cycle after any error status bit is 1 while the matching bit of the error enable register (address 5) is 1. A disabled error bit never sets it.
- R4: The event enable bits at address 6 are 0 RX full, 1 TX empty, 2 RX watermark, 3 TX watermark, 4 ready and 5 idle. Idle is true while active_i is 0. Interrupt state bit 1 is set in the cycle after any enabled event is present.
- R5: Writing 1 to bit b of the interrupt state register (address 0) clears state bit b. If the enabled source of that bit is still present, the bit stays set.
- R6: Writing 1 to bit b of the interrupt test register (address 2) sets interrupt state bit b. Writing 0 has no effect.
- R7: irq_err_o equals interrupt state bit 0 AND enable bit 0. irq_evt_o equals state bit 1 AND enable bit 1. The enable register is at address 1.
- R8: A write with bit 0 = 1 to address 3 drives alert_fatal_o high for exactly the cycle after the write edge. A write of 0 to that address leaves it low.
- R9: rd_data_o shows, one clock after rd_addr_i is presented, the register at that address, zero-extended. Addresses 2 and 3 and any unused address read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write word address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 3 | Register read word address |
| rd_data_o | output | DATA_W | Registered read data |
| err_set_i | input | 5 | Error condition pulses, one per error status bit |
| evt_i | input | 5 | Event levels: RX full, TX empty, RX watermark, TX watermark, ready |
| active_i | input | 1 | Sequencer active level; its inverse is the idle event |
| irq_err_o | output | 1 | Error interrupt |
| irq_evt_o | output | 1 | Transfer event interrupt |
| alert_fatal_o | output | 1 | One-cycle fatal alert pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit data word and an error enable reset value of 0x1F. With these values the reset check can see every error enable bit set, and the read-back of each register covers its full width. The stimulus table exercises a clear that collides with a still-present source, and a set that collides with a clear. It also covers masking by each of the two enable levels and the idle event driven from the active level. Directed tests cover the alert pulse width and a reset issued in the middle of the run.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int ERR_W  = 5;
  localparam int EVT_W  = 6;
  localparam int IRQ_W  = 2;
  localparam int ADDR_W = 3;

  // interrupt state / enable / test bit positions
  localparam int IRQ_ERR = 0;
  localparam int IRQ_EVT = 1;

  // event enable bit positions (idle is the top bit)
  localparam int EVT_IDLE = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_ISTATE = 3'd0,
    A_IEN    = 3'd1,
    A_ITEST  = 3'd2,
    A_ALERT  = 3'd3,
    A_ESTAT  = 3'd4,
    A_EEN    = 3'd5,
    A_EVEN   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i) begin
      if (rst_i)          q_o[i] <= 1'b0;
      else if (set_i[i])  q_o[i] <= 1'b1;
      else if (clr_i[i])  q_o[i] <= 1'b0;
    end
  end

  // R2
  set_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((q_o & $past(set_i)) == $past(set_i)));
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> ((q_o & $past(q_o & ~clr_i)) == $past(q_o & ~clr_i)));
endmodule

// File: rtl/irq_mask_reduce.sv
module irq_mask_reduce #(
  parameter int W = 6
) (
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] mask_i,
  output logic         any_o
);
  assign any_o = |(src_i & mask_i);
endmodule

// File: rtl/spi_host_irq_agg.sv
module spi_host_irq_agg
  import spi_irq_pkg::*;
#(
  parameter int               DATA_W     = 32,
  parameter logic [ERR_W-1:0] ERR_EN_RST = 5'h1F
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [DATA_W-1:0]     rd_data_o,
  input  logic [ERR_W-1:0]      err_set_i,
  input  logic [EVT_W-2:0]      evt_i,
  input  logic                  active_i,
  output logic                  irq_err_o,
  output logic                  irq_evt_o,
  output logic                  alert_fatal_o
);
  logic [IRQ_W-1:0] int_en_q, int_state_q, state_set, state_clr, test_bits;
  logic [ERR_W-1:0] err_en_q, err_stat_q, err_clr;
  logic [EVT_W-1:0] evt_en_q, evt_vec;
  logic             err_any, evt_any, alert_q;
  logic             unused_wdata;

  assign unused_wdata = ^wr_data_i[DATA_W-1:EVT_W];

  function automatic logic hit(input reg_addr_e a);
    return wr_en_i && (wr_addr_i == a);
  endfunction

  // enable registers
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      int_en_q <= '0;
      err_en_q <= ERR_EN_RST;
      evt_en_q <= '0;
    end else begin
      if (hit(A_IEN))  int_en_q <= wr_data_i[IRQ_W-1:0];
      if (hit(A_EEN))  err_en_q <= wr_data_i[ERR_W-1:0];
      if (hit(A_EVEN)) evt_en_q <= wr_data_i[EVT_W-1:0];
    end
  end

  // sticky error status
  assign err_clr = hit(A_ESTAT) ? wr_data_i[ERR_W-1:0] : '0;

  irq_sticky_bank #(.W(ERR_W)) u_err_bank (
    .clk_i(clk_i), .rst_i(rst_i),
    .set_i(err_set_i), .clr_i(err_clr), .q_o(err_stat_q)
  );

  irq_mask_reduce #(.W(ERR_W)) u_err_red (
    .src_i(err_stat_q), .mask_i(err_en_q), .any_o(err_any)
  );

  // event sources, idle derived from the active level
  assign evt_vec = {~active_i, evt_i};

  irq_mask_reduce #(.W(EVT_W)) u_evt_red (
    .src_i(evt_vec), .mask_i(evt_en_q), .any_o(evt_any)
  );

  // interrupt state
  assign test_bits = hit(A_ITEST)  ? wr_data_i[IRQ_W-1:0] : '0;
  assign state_clr = hit(A_ISTATE) ? wr_data_i[IRQ_W-1:0] : '0;
  assign state_set = {evt_any, err_any} | test_bits;

  irq_sticky_bank #(.W(IRQ_W)) u_state_bank (
    .clk_i(clk_i), .rst_i(rst_i),
    .set_i(state_set), .clr_i(state_clr), .q_o(int_state_q)
  );

  assign irq_err_o = int_state_q[IRQ_ERR] & int_en_q[IRQ_ERR];
  assign irq_evt_o = int_state_q[IRQ_EVT] & int_en_q[IRQ_EVT];

  // alert pulse and read port
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      alert_q   <= 1'b0;
      rd_data_o <= '0;
    end else begin
      alert_q <= hit(A_ALERT) & wr_data_i[0];
      case (rd_addr_i)
        A_ISTATE: rd_data_o <= DATA_W'(int_state_q);
        A_IEN:    rd_data_o <= DATA_W'(int_en_q);
        A_ESTAT:  rd_data_o <= DATA_W'(err_stat_q);
        A_EEN:    rd_data_o <= DATA_W'(err_en_q);
        A_EVEN:   rd_data_o <= DATA_W'(evt_en_q);
        default:  rd_data_o <= '0;
      endcase
    end
  end
  assign alert_fatal_o = alert_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    rst_i |=> (!alert_fatal_o && !irq_err_o && !irq_evt_o));
  // R3
  err_to_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    err_any |=> int_state_q[IRQ_ERR]);
  // R4
  evt_to_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_any |=> int_state_q[IRQ_EVT]);
  // R6
  test_force_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i == A_ITEST) |=>
      ((int_state_q & $past(wr_data_i[IRQ_W-1:0])) == $past(wr_data_i[IRQ_W-1:0])));
  // R8
  alert_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    alert_fatal_o |-> $past(wr_en_i && wr_addr_i == A_ALERT && wr_data_i[0]));
endmodule

// File: tb/tb_spi_host_irq_agg.sv
module tb_spi_host_irq_agg;
  localparam int DW = 32;
  localparam int NV = 31;
  // {we, addr[3], wdata[8], eset[5], evt[5], act, raddr[3], rexp[8], iexp{evt,err}}
  localparam logic [35:0] VEC [NV] = '{
    {1'b1,3'd1,8'h03,5'h00,5'h00,1'b1,3'd1,8'h03,2'b00}, // 0  R7
    {1'b0,3'd0,8'h00,5'h02,5'h00,1'b1,3'd4,8'h02,2'b01}, // 1  R2 R3
    {1'b1,3'd0,8'h01,5'h00,5'h00,1'b1,3'd0,8'h01,2'b01}, // 2  R5
    {1'b1,3'd4,8'h02,5'h00,5'h00,1'b1,3'd4,8'h00,2'b01}, // 3  R2
    {1'b1,3'd0,8'h01,5'h00,5'h00,1'b1,3'd0,8'h00,2'b00}, // 4  R5
    {1'b1,3'd5,8'h1D,5'h02,5'h00,1'b1,3'd0,8'h00,2'b00}, // 5  R3
    {1'b1,3'd5,8'h1F,5'h00,5'h00,1'b1,3'd0,8'h01,2'b01}, // 6  R3
    {1'b1,3'd4,8'h1F,5'h00,5'h00,1'b1,3'd4,8'h00,2'b01}, // 7  R2
    {1'b1,3'd0,8'h03,5'h00,5'h00,1'b1,3'd0,8'h00,2'b00}, // 8  R5
    {1'b1,3'd4,8'h10,5'h10,5'h00,1'b1,3'd4,8'h10,2'b01}, // 9  R2
    {1'b1,3'd4,8'h10,5'h00,5'h00,1'b1,3'd4,8'h00,2'b01}, // 10 R2
    {1'b1,3'd0,8'h01,5'h00,5'h00,1'b1,3'd0,8'h00,2'b00}, // 11 R5
    {1'b1,3'd6,8'h01,5'h00,5'h01,1'b1,3'd0,8'h02,2'b10}, // 12 R4
    {1'b1,3'd0,8'h02,5'h00,5'h01,1'b1,3'd0,8'h02,2'b10}, // 13 R5
    {1'b1,3'd0,8'h02,5'h00,5'h00,1'b1,3'd0,8'h00,2'b00}, // 14 R5
    {1'b0,3'd0,8'h00,5'h00,5'h10,1'b1,3'd0,8'h00,2'b00}, // 15 R4
    {1'b1,3'd6,8'h10,5'h00,5'h10,1'b1,3'd0,8'h02,2'b10}, // 16 R4
    {1'b1,3'd0,8'h02,5'h00,5'h00,1'b1,3'd0,8'h00,2'b00}, // 17 R5
    {1'b1,3'd6,8'h20,5'h00,5'h00,1'b0,3'd0,8'h02,2'b10}, // 18 R4
    {1'b1,3'd0,8'h02,5'h00,5'h00,1'b1,3'd0,8'h00,2'b00}, // 19 R5
    {1'b1,3'd2,8'h01,5'h00,5'h00,1'b1,3'd0,8'h01,2'b01}, // 20 R6
    {1'b1,3'd1,8'h02,5'h00,5'h00,1'b1,3'd0,8'h01,2'b00}, // 21 R7
    {1'b1,3'd2,8'h02,5'h00,5'h00,1'b1,3'd0,8'h03,2'b10}, // 22 R6
    {1'b1,3'd2,8'h00,5'h00,5'h00,1'b1,3'd0,8'h03,2'b10}, // 23 R6
    {1'b1,3'd0,8'h03,5'h00,5'h00,1'b1,3'd0,8'h00,2'b00}, // 24 R5
    {1'b0,3'd0,8'h00,5'h00,5'h00,1'b1,3'd2,8'h00,2'b00}, // 25 R9
    {1'b0,3'd0,8'h00,5'h01,5'h00,1'b1,3'd4,8'h01,2'b00}, // 26 R2
    {1'b1,3'd4,8'h01,5'h00,5'h00,1'b1,3'd0,8'h01,2'b00}, // 27 R2
    {1'b1,3'd0,8'h01,5'h00,5'h00,1'b1,3'd0,8'h00,2'b00}, // 28 R5
    {1'b1,3'd6,8'h0E,5'h00,5'h04,1'b1,3'd0,8'h02,2'b10}, // 29 R4
    {1'b1,3'd0,8'h02,5'h00,5'h00,1'b1,3'd0,8'h00,2'b00}  // 30 R5
  };

  logic clk = 0, rst = 1;
  logic wr_en = 0, active = 1;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [DW-1:0] wr_data = 0, rd_data;
  logic [4:0] err_set = 0, evt = 0;
  logic irq_err, irq_evt, alert;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  spi_host_irq_agg dut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .err_set_i(err_set), .evt_i(evt), .active_i(active),
    .irq_err_o(irq_err), .irq_evt_o(irq_evt), .alert_fatal_o(alert)
  );

  function automatic string tag_of(input int i);
    case (i)
      0, 21:                      return "R7";
      1, 3, 7, 9, 10, 26, 27:     return "R2";
      5, 6:                       return "R3";
      12, 15, 16, 18, 29:         return "R4";
      20, 22, 23:                 return "R6";
      25:                         return "R9";
      default:                    return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [31:0] exp);
    @(negedge clk); rd_addr = a;
    @(negedge clk); chk(tag, rd_data, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    chk("R1", {29'd0, irq_evt, irq_err, alert}, 0);
    rd(3'd0, "R1", 32'h00);
    rd(3'd1, "R1", 32'h00);
    rd(3'd4, "R1", 32'h00);
    rd(3'd5, "R1", 32'h1F);
    rd(3'd6, "R1", 32'h00);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      @(negedge clk);
      wr_en = v[35]; wr_addr = v[34:32]; wr_data = {24'd0, v[31:24]};
      err_set = v[23:19]; evt = v[18:14]; active = v[13]; rd_addr = v[12:10];
      @(negedge clk); wr_en = 0; err_set = 0;
      @(negedge clk);
      @(negedge clk);
      chk(tag_of(i), rd_data, {24'd0, v[9:2]});
      chk(tag_of(i), {30'd0, irq_evt, irq_err}, {30'd0, v[1:0]});
    end

    // R8 alert pulse: high one cycle after the write edge, then low
    @(negedge clk); wr_en = 1; wr_addr = 3'd3; wr_data = 32'h1;
    @(negedge clk); wr_en = 0;
    chk("R8", {31'd0, alert}, 1);
    @(negedge clk); chk("R8", {31'd0, alert}, 0);
    wr(3'd3, 32'h0);
    chk("R8", {31'd0, alert}, 0);

    // R1 reset mid-run
    wr(3'd1, 32'h3);
    wr(3'd2, 32'h3);
    chk("R7", {30'd0, irq_evt, irq_err}, 32'h3);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1", {29'd0, irq_evt, irq_err, alert}, 0);
    rd(3'd1, "R1", 32'h0);
    rd(3'd5, "R1", 32'h1F);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule